// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address into a physical address using a segment table kept in memory. A logical address is made of a segment number and an offset within that segment. For each accepted request the block reads one table entry. The entry's location comes from a table-base input plus the segment number scaled by the entry size. The block then checks that the segment is present and that the offset lies inside it. When both checks pass, it returns the segment base plus the offset. When a check fails, it returns a fault code.

The block handles one translation at a time. The request, memory-read and response channels each use a valid/ready handshake, except the memory read data, which arrives as a single-cycle pulse. The block caches no translation, so every request costs exactly one memory read.

Top module: `seg_xlate`

## Requirements
- R1: While reset is held, and after it is released with no request, `req_ready` is 1 and both `mem_req_valid` and `resp_valid` are 0.
- R2: The entry address is `tbl_base + 8 * req_seg`, taken from `tbl_base` in the cycle the request is accepted. The address stays stable while `mem_req_valid` is high and `mem_req_ready` is low, even if `tbl_base` changes.
- R3: The entry layout is: base in bits 31:0, present flag in bit 32, length in bits 56:33. If the present flag is 0, the response carries fault code 2'b01 and address 0.
- R4: If the present flag is 1 and the offset is greater than or equal to the length, the response carries fault code 2'b10 and address 0. An offset equal to the length faults, and a length of 0 faults every offset.
- R5: If the present flag is 1 and the offset is below the length, the response carries fault code 2'b00. The address is the base plus the zero-extended offset, modulo 2^32.
- R6: When the present flag is 0 and the offset is also out of range, the fault code is 2'b01.
- R7: Exactly one memory read is issued per request. `req_ready` stays 0 from acceptance until the response is taken.
- R8: `resp_valid` rises in the cycle after the one in which `mem_rsp_valid` is seen. The response holds steady until `resp_ready` is high, and a `mem_rsp_valid` pulse during that time has no effect.
- R9: Entry bits 63:57 are reserved and have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_base | input | 32 | Byte address of the segment table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_seg | input | 8 | Segment number |
| req_off | input | 24 | Offset within the segment |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid (one-cycle pulse) |
| mem_rsp_data | input | 64 | Segment table entry |
| resp_valid | output | 1 | Translation result valid |
| resp_ready | input | 1 | Consumer takes the result |
| resp_paddr | output | 32 | Physical address, 0 on fault |
| resp_fault | output | 2 | 00 none, 01 not present, 10 out of bounds |

## Verification
The read request is due one cycle after the request handshake, when the bench checks its address. The response is due exactly one cycle after the cycle in which entry data is presented. The bench drives every input on the falling edge and samples on the next falling edge, so each check reads a value that has settled after exactly one register stage. During inserted stalls, and for the response latency, the bench checks at every falling edge that the result has not yet appeared. During held responses, it checks at every falling edge that the values have not moved.

// File: rtl/seg_xlate_pkg.sv
// Shared types for the segment translator.
// Assumes: fault encodings are fixed by the interface contract.
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_BOUNDS = 2'b10
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_RESP
    } state_e;

endpackage

// File: rtl/seg_xlate_addr.sv
// Entry locator: forms the byte address of a segment table entry.
// Assumes: ENT_BYTES is a power of two and SEG_W < ADDR_W.
module seg_xlate_addr #(
    parameter int SEG_W     = 8,
    parameter int ADDR_W    = 32,
    parameter int ENT_BYTES = 8
) (
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [SEG_W-1:0]  seg,
    output logic [ADDR_W-1:0] ent_addr
);
    localparam int SHIFT = $clog2(ENT_BYTES);

    logic [ADDR_W-1:0] seg_ext;

    // Scale the segment number by the entry size and add the table base.
    always_comb begin
        seg_ext  = {{(ADDR_W-SEG_W){1'b0}}, seg};
        ent_addr = tbl_base + (seg_ext << SHIFT);
    end
endmodule

// File: rtl/seg_xlate_check.sv
// Entry checker: decodes an entry, applies the present and bounds checks
// (present has priority), and forms base + offset on success.
// Assumes: entry layout is base at [ADDR_W-1:0], present at ADDR_W,
// length just above it; any higher bits are reserved.
module seg_xlate_check
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 24,
    parameter int ENT_W  = 64
) (
    input  logic [ENT_W-1:0]  entry,
    input  logic [OFF_W-1:0]  off,
    output fault_e            fault,
    output logic [ADDR_W-1:0] paddr
);
    localparam int PRES_POS = ADDR_W;
    localparam int LEN_LSB  = ADDR_W + 1;
    localparam int LEN_MSB  = LEN_LSB + OFF_W - 1;

    logic [ADDR_W-1:0] seg_base;
    logic              seg_pres;
    logic [OFF_W-1:0]  seg_len;

    assign seg_base = entry[ADDR_W-1:0];
    assign seg_pres = entry[PRES_POS];
    assign seg_len  = entry[LEN_MSB:LEN_LSB];

    generate
        if (ENT_W > LEN_MSB + 1) begin : g_rsv
            logic unused_rsv;
            assign unused_rsv = ^entry[ENT_W-1:LEN_MSB+1];
        end
    endgenerate

    // Present check first, then bounds, then address formation.
    always_comb begin
        if (!seg_pres) begin
            fault = FLT_ABSENT;
            paddr = '0;
        end else if (off >= seg_len) begin
            fault = FLT_BOUNDS;
            paddr = '0;
        end else begin
            fault = FLT_NONE;
            paddr = seg_base + {{(ADDR_W-OFF_W){1'b0}}, off};
        end
    end
endmodule

// File: rtl/seg_xlate_ctrl.sv
// Sequencer: accepts one request, issues one entry read, waits for the
// data, registers the checked result and holds it until taken.
// Assumes: memory data returns as a single-cycle pulse after the read.
module seg_xlate_ctrl
    import seg_xlate_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] ent_addr_d,
    input  logic [OFF_W-1:0]  off_d,
    output logic [OFF_W-1:0]  off_q,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  fault_e            chk_fault,
    input  logic [ADDR_W-1:0] chk_paddr,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic [1:0]        resp_fault
);
    state_e            state;
    logic [ADDR_W-1:0] addr_q;
    fault_e            fault_q;
    logic [ADDR_W-1:0] paddr_q;

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_FETCH);
    assign resp_valid    = (state == ST_RESP);
    assign mem_req_addr  = addr_q;
    assign resp_paddr    = paddr_q;
    assign resp_fault    = fault_q;

    // Advance through accept, fetch, wait and respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (req_valid)     state <= ST_FETCH;
                ST_FETCH: if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT:  if (mem_rsp_valid) state <= ST_RESP;
                ST_RESP:  if (resp_ready)    state <= ST_IDLE;
                default:                     state <= ST_IDLE;
            endcase
        end
    end

    // Capture the entry address and offset when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            off_q  <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            addr_q <= ent_addr_d;
            off_q  <= off_d;
        end
    end

    // Register the checked result when the entry arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= FLT_NONE;
            paddr_q <= '0;
        end else if (state == ST_WAIT && mem_rsp_valid) begin
            fault_q <= chk_fault;
            paddr_q <= chk_paddr;
        end
    end

    AST_READ_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R2
    AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> resp_fault != 2'b11); // R3
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_fault != 2'b00 |-> resp_paddr == '0); // R4
    AST_READ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid); // R7
    AST_BUSY_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_ready |=> !req_ready); // R7
    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_ready |=> resp_valid && $stable(resp_paddr) && $stable(resp_fault)); // R8
    AST_RESP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resp_valid) |-> $past(mem_rsp_valid)); // R8
endmodule

// File: rtl/seg_xlate.sv
// Segment table translator top: wires the entry locator, the sequencer
// and the entry checker together.
// Assumes: one request in flight; entries are ENT_BYTES wide in memory.
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W  = 8,
    parameter int OFF_W  = 24,
    parameter int ADDR_W = 32,
    parameter int ENT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ENT_W-1:0]  mem_rsp_data,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic [1:0]        resp_fault
);
    localparam int ENT_BYTES = ENT_W / 8;

    logic [ADDR_W-1:0] ent_addr;
    logic [OFF_W-1:0]  off_q;
    fault_e            chk_fault;
    logic [ADDR_W-1:0] chk_paddr;

    seg_xlate_addr #(
        .SEG_W(SEG_W), .ADDR_W(ADDR_W), .ENT_BYTES(ENT_BYTES)
    ) u_addr (
        .tbl_base (tbl_base),
        .seg      (req_seg),
        .ent_addr (ent_addr)
    );

    seg_xlate_ctrl #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .ent_addr_d    (ent_addr),
        .off_d         (req_off),
        .off_q         (off_q),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .chk_fault     (chk_fault),
        .chk_paddr     (chk_paddr),
        .resp_valid    (resp_valid),
        .resp_ready    (resp_ready),
        .resp_paddr    (resp_paddr),
        .resp_fault    (resp_fault)
    );

    seg_xlate_check #(
        .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENT_W(ENT_W)
    ) u_check (
        .entry (mem_rsp_data),
        .off   (off_q),
        .fault (chk_fault),
        .paddr (chk_paddr)
    );
endmodule

// File: tb/seg_xlate_bench.sv
// Directed bench for the segment translator; the bench acts as the memory.
module seg_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tbl_base = 32'h0001_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_seg = '0;
    logic [23:0] req_off = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        resp_valid;
    logic        resp_ready = 1'b0;
    logic [31:0] resp_paddr;
    logic [1:0]  resp_fault;

    int n_checks = 0;
    int n_fails  = 0;
    int rd_count = 0;

    always #5 clk = ~clk;

    seg_xlate u_seg_xlate (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_off(req_off),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .resp_valid(resp_valid),
        .resp_ready(resp_ready), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault)
    );

    always @(posedge clk)
        if (rst_n && mem_req_valid && mem_req_ready) rd_count <= rd_count + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_ent(input logic [31:0] base, input logic pres,
                                           input logic [23:0] len, input logic [6:0] rsv);
        return {rsv, len, pres, base};
    endfunction

    // One translation: stall = cycles memory refuses the read, lat = cycles
    // before entry data, hold = cycles the consumer stalls the response.
    task automatic run_xlate(input logic [7:0] seg, input logic [23:0] off,
                             input logic [63:0] ent, input int stall, input int lat,
                             input int hold, input logic [1:0] ef,
                             input logic [31:0] ep, input logic [31:0] ea,
                             input string req);
        int rd0;
        logic [31:0] base_keep;
        @(negedge clk);
        rd0 = rd_count;
        req_valid = 1'b1; req_seg = seg; req_off = off;
        mem_req_ready = (stall == 0);
        @(negedge clk);
        req_valid = 1'b0; req_seg = ~seg; req_off = ~off;
        base_keep = tbl_base;
        tbl_base = tbl_base ^ 32'hFFFF_0000;
        chk(mem_req_valid, "R2", "read issued", 64'(mem_req_valid), 64'd1);
        chk(mem_req_addr == ea, "R2", "entry address", 64'(mem_req_addr), 64'(ea));
        chk(!req_ready, "R7", "busy after accept", 64'(req_ready), 64'd0);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            chk(mem_req_valid && mem_req_addr == ea, "R2", "read held in stall",
                64'(mem_req_addr), 64'(ea));
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        tbl_base = base_keep;
        chk(!mem_req_valid, "R7", "read dropped", 64'(mem_req_valid), 64'd0);
        for (int i = 0; i < lat; i++) begin
            chk(!resp_valid, "R8", "no early response", 64'(resp_valid), 64'd0);
            @(negedge clk);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = ent;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = ~ent;
        chk(resp_valid, "R8", "response one cycle after data", 64'(resp_valid), 64'd1);
        chk(resp_fault == ef, req, "fault code", 64'(resp_fault), 64'(ef));
        chk(resp_paddr == ep, req, "physical address", 64'(resp_paddr), 64'(ep));
        for (int i = 0; i < hold; i++) begin
            mem_rsp_valid = 1'b1;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk(resp_valid && resp_fault == ef && resp_paddr == ep, "R8",
                "response held", {30'd0, resp_fault, resp_paddr}, {30'd0, ef, ep});
            chk(!req_ready, "R7", "busy while held", 64'(req_ready), 64'd0);
        end
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        chk(!resp_valid && req_ready, "R7", "idle after take",
            {62'd0, resp_valid, req_ready}, 64'd1);
        chk(rd_count - rd0 == 1, "R7", "reads per request", 64'(rd_count - rd0), 64'd1);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(req_ready && !mem_req_valid && !resp_valid, "R1", "in reset",
            {61'd0, req_ready, mem_req_valid, resp_valid}, 64'd4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(req_ready && !mem_req_valid && !resp_valid, "R1", "after reset",
            {61'd0, req_ready, mem_req_valid, resp_valid}, 64'd4);
    endtask

    task automatic t_hit;
        run_xlate(8'd3, 24'h000100, mk_ent(32'h2000_0000, 1'b1, 24'h001000, 7'd0),
                  0, 0, 0, 2'b00, 32'h2000_0100, 32'h0001_0018, "R5");
    endtask

    task automatic t_absent;
        run_xlate(8'd5, 24'h000010, mk_ent(32'h3000_0000, 1'b0, 24'h000100, 7'd0),
                  2, 1, 1, 2'b01, 32'h0, 32'h0001_0028, "R3");
    endtask

    task automatic t_bounds_edge;
        run_xlate(8'd0, 24'h000200, mk_ent(32'h4000_0000, 1'b1, 24'h000200, 7'd0),
                  0, 3, 0, 2'b10, 32'h0, 32'h0001_0000, "R4");
        run_xlate(8'd0, 24'h0001FF, mk_ent(32'h4000_0000, 1'b1, 24'h000200, 7'd0),
                  1, 0, 2, 2'b00, 32'h4000_01FF, 32'h0001_0000, "R5");
        run_xlate(8'd255, 24'hFFFFFF, mk_ent(32'h5000_0000, 1'b1, 24'h800000, 7'd0),
                  0, 0, 0, 2'b10, 32'h0, 32'h0001_07F8, "R4");
        run_xlate(8'd4, 24'h000000, mk_ent(32'h6000_0000, 1'b1, 24'h000000, 7'd0),
                  0, 1, 0, 2'b10, 32'h0, 32'h0001_0020, "R4");
    endtask

    task automatic t_priority;
        run_xlate(8'd7, 24'h000500, mk_ent(32'h7000_0000, 1'b0, 24'h000010, 7'd0),
                  0, 0, 0, 2'b01, 32'h0, 32'h0001_0038, "R6");
    endtask

    task automatic t_wrap;
        run_xlate(8'd1, 24'h000200, mk_ent(32'hFFFF_FF00, 1'b1, 24'hFFFFFF, 7'd0),
                  0, 0, 0, 2'b00, 32'h0000_0100, 32'h0001_0008, "R5");
    endtask

    task automatic t_reserved;
        run_xlate(8'd2, 24'h000034, mk_ent(32'h1234_0000, 1'b1, 24'h000040, 7'h7F),
                  0, 0, 0, 2'b00, 32'h1234_0034, 32'h0001_0010, "R9");
        run_xlate(8'd2, 24'h000040, mk_ent(32'h1234_0000, 1'b1, 24'h000040, 7'h55),
                  0, 0, 0, 2'b10, 32'h0, 32'h0001_0010, "R9");
    endtask

    task automatic t_new_base;
        tbl_base = 32'h8000_0000;
        run_xlate(8'h10, 24'h000008, mk_ent(32'h0000_1000, 1'b1, 24'h000100, 7'd0),
                  3, 2, 3, 2'b00, 32'h0000_1008, 32'h8000_0080, "R2");
        tbl_base = 32'h0001_0000;
    endtask

    initial begin
        t_reset;
        t_hit;
        t_absent;
        t_bounds_edge;
        t_priority;
        t_wrap;
        t_reserved;
        t_new_base;
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule